// File: doc/BRIEF.md
# Root Port Error Collector and Interrupt Generator

This block sits in a root port and collects the error messages that reach it. Each message carries a severity (correctable, non-fatal uncorrectable or fatal uncorrectable) and a 16-bit requester identity. The block keeps a root error status register with received and multiple-received flags, records the identity of the first correctable and the first uncorrectable sender, and holds the software command enables that decide which severities raise the advanced error interrupt.

The interrupt leaves the block in one of two forms, chosen by a mode input. In level mode it is a wire-style level that stays high while any enabled severity is marked received. In message mode it is a one-cycle pulse, tagged with an interrupt message number, issued only when the enabled-and-received condition turns from false to true. That message number is fixed by the surrounding logic through a side load input and is visible to software but not writable by it. Software reaches the command, status and source registers through a small word-addressed register port with a combinational read path.

Top module: `root_err_collector`

## Requirements
- R1: A correctable message (severity code 0) sets status bit 0 (correctable received). If bit 0 was already set before that cycle it sets bit 1 (multiple correctable) and the source register is unchanged; otherwise the message identity is stored in source register bits [15:0].
- R2: A fatal message (severity code 2) sets status bit 6 and also sets bit 4 (first uncorrectable was fatal) only when bit 2 was clear before that cycle; a non-fatal message (severity code 1) sets bit 5.
- R3: Any uncorrectable message (code 1 or 2) sets status bit 2. If bit 2 was already set it sets bit 3 (multiple uncorrectable) and leaves source bits [31:16] unchanged; otherwise the identity is stored in source bits [31:16].
- R4: The command register at address 0 holds three read/write enables in bits [2:0]: bit 0 correctable, bit 1 non-fatal, bit 2 fatal; other bits read zero. Address 1 is status, address 2 is source, address 3 reads zero.
- R5: In message mode (mode input 1) a message whose severity is enabled raises a one-cycle pulse in the cycle after its edge only if no previously received severity was already enabled.
- R6: In message mode a command write raises the pulse only when the enabled-and-received condition was false before the write and true after it; the pulse never lasts more than one cycle.
- R7: In level mode (mode input 0) the interrupt level equals the OR over the three severities of (enable bit AND its received bit: bit 0, bit 5, bit 6), following every command write and status change.
- R8: Status bits [31:27] show the interrupt message number, which only the side load input changes; software writes to it have no effect. The number is also driven on the vector output alongside the pulse.
- R9: Status bits [6:0] are write-one-to-clear at address 1. A message in the same cycle as a clear sets its bits anyway, and its first/multiple decisions use the status value from before that cycle.
- R10: Severity code 3 is ignored: no status, source or interrupt change.
- R11: After reset the command, status, source and message number are zero and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | An error message is presented this cycle |
| msg_sev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal, 3 ignored |
| msg_src | input | 16 | Identity of the message sender |
| msg_mode | input | 1 | 0 level interrupt, 1 message (pulse) interrupt |
| vec_load | input | 1 | Load the interrupt message number |
| vec_in | input | 5 | New interrupt message number |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| intx_level | output | 1 | Level interrupt |
| msi_pulse | output | 1 | One-cycle message interrupt request |
| msi_vector | output | 5 | Interrupt message number carried with the pulse |

## Verification
The bench drives a second message of each class to check that the multiple flags rise while the captured source stays put; a design that captured on every message would show the newest sender. It sends a fatal message after a non-fatal one, where a design ignoring the earlier uncorrectable would wrongly flag first-fatal, and it clears status in the same cycle as a new message, where a clear-wins design would lose the bit. In message mode it enables a severity only after that error is received and then widens the enables, so a design that pulsed on any enabled write, or on each new message while already active, would produce extra pulses; software writes into the message number field check that it cannot be altered.

// File: rtl/rec_pkg.sv
package rec_pkg;
   typedef enum logic [1:0] {
      SEV_COR      = 2'd0,
      SEV_NONFATAL = 2'd1,
      SEV_FATAL    = 2'd2,
      SEV_NONE     = 2'd3
   } sev_e;

   // Status bit positions (decoded by software)
   localparam int ST_COR   = 0;
   localparam int ST_MCOR  = 1;
   localparam int ST_UNC   = 2;
   localparam int ST_MUNC  = 3;
   localparam int ST_FFAT  = 4;
   localparam int ST_NF    = 5;
   localparam int ST_FAT   = 6;
   localparam int ST_BITS  = 7;
   localparam int CMD_BITS = 3;

   function automatic logic enabled_rcv(input logic [CMD_BITS-1:0] cmd,
                                        input logic [ST_BITS-1:0] st);
      return |(cmd & {st[ST_FAT], st[ST_NF], st[ST_COR]});
   endfunction
endpackage

// File: rtl/rec_status.sv
module rec_status import rec_pkg::*; #(
   parameter int SRC_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               msg_valid,
   input  sev_e               msg_sev,
   input  logic [SRC_W-1:0]   msg_src,
   input  logic [ST_BITS-1:0] clr,
   output logic [ST_BITS-1:0] st,
   output logic [ST_BITS-1:0] st_nxt,
   output logic [SRC_W-1:0]   src_cor,
   output logic [SRC_W-1:0]   src_unc
);
   logic [ST_BITS-1:0] set_bits;
   logic               cap_cor;
   logic               cap_unc;

   always_comb begin
      set_bits = '0;
      cap_cor  = 1'b0;
      cap_unc  = 1'b0;
      if (msg_valid) begin
         case (msg_sev)
            SEV_COR: begin
               if (st[ST_COR]) set_bits[ST_MCOR] = 1'b1;
               else            cap_cor = 1'b1;
               set_bits[ST_COR] = 1'b1;
            end
            SEV_NONFATAL, SEV_FATAL: begin
               if (st[ST_UNC]) set_bits[ST_MUNC] = 1'b1;
               else            cap_unc = 1'b1;
               set_bits[ST_UNC] = 1'b1;
               if (msg_sev == SEV_FATAL) begin
                  if (!st[ST_UNC]) set_bits[ST_FFAT] = 1'b1;
                  set_bits[ST_FAT] = 1'b1;
               end else begin
                  set_bits[ST_NF] = 1'b1;
               end
            end
            default: ;
         endcase
      end
      st_nxt = (st & ~clr) | set_bits;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= '0;
         src_cor <= '0;
         src_unc <= '0;
      end else begin
         st <= st_nxt;
         if (cap_cor) src_cor <= msg_src;
         if (cap_unc) src_unc <= msg_src;
      end
   end

   // R1: a repeat correctable marks multiple and keeps the first source
   p_multi_cor_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_sev == SEV_COR && st[ST_COR])
      |=> (st[ST_MCOR] && $stable(src_cor)));

   // R2: fatal after an earlier uncorrectable leaves first-fatal alone
   p_first_fatal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_sev == SEV_FATAL && st[ST_UNC] && !clr[ST_FFAT])
      |=> (st[ST_FFAT] == $past(st[ST_FFAT])));

   // R3: a repeat uncorrectable marks multiple and keeps the first source
   p_multi_unc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && (msg_sev == SEV_NONFATAL || msg_sev == SEV_FATAL) && st[ST_UNC])
      |=> (st[ST_MUNC] && $stable(src_unc)));

   // R9: a message wins over a same-cycle clear of its received bit
   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_sev == SEV_COR && clr[ST_COR]) |=> st[ST_COR]);

   // R10: the unused severity code changes nothing
   p_ignored_sev_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_sev == SEV_NONE && clr == '0)
      |=> ($stable(st) && $stable(src_cor) && $stable(src_unc)));
endmodule

// File: rtl/rec_irq.sv
module rec_irq import rec_pkg::*; #(
   parameter int VEC_W    = 5,
   parameter bit INTX_REG = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                msg_mode,
   input  logic [CMD_BITS-1:0] cmd,
   input  logic [CMD_BITS-1:0] cmd_nxt,
   input  logic [ST_BITS-1:0]  st,
   input  logic [ST_BITS-1:0]  st_nxt,
   input  logic                vec_load,
   input  logic [VEC_W-1:0]    vec_in,
   output logic                intx_level,
   output logic                msi_pulse,
   output logic [VEC_W-1:0]    vec
);
   logic en_cur;
   logic en_nxt;

   assign en_cur = enabled_rcv(cmd, st);
   assign en_nxt = enabled_rcv(cmd_nxt, st_nxt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msi_pulse <= 1'b0;
         vec       <= '0;
      end else begin
         msi_pulse <= msg_mode & ~en_cur & en_nxt;
         if (vec_load) vec <= vec_in;
      end
   end

   generate
      if (INTX_REG) begin : g_intx_reg
         always_ff @(posedge clk) begin
            if (!rst_n) intx_level <= 1'b0;
            else        intx_level <= ~msg_mode & en_nxt;
         end
      end else begin : g_intx_comb
         assign intx_level = ~msg_mode & en_cur;
      end
   endgenerate

   // R5: a pulse only follows an edge taken in message mode
   p_pulse_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      msi_pulse |-> $past(msg_mode));

   // R6: the pulse is a single cycle
   p_pulse_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      msi_pulse |=> !msi_pulse);

   // R8: the message number moves only on the side load
   p_vec_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_load |=> $stable(vec));
endmodule

// File: rtl/root_err_collector.sv
module root_err_collector import rec_pkg::*; #(
   parameter int SRC_W    = 16,
   parameter int VEC_W    = 5,
   parameter int DATA_W   = 32,
   parameter bit INTX_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msg_valid,
   input  logic [1:0]        msg_sev,
   input  logic [SRC_W-1:0]  msg_src,
   input  logic              msg_mode,
   input  logic              vec_load,
   input  logic [VEC_W-1:0]  vec_in,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              intx_level,
   output logic              msi_pulse,
   output logic [VEC_W-1:0]  msi_vector
);
   localparam logic [1:0] A_CMD = 2'd0;
   localparam logic [1:0] A_ST  = 2'd1;
   localparam logic [1:0] A_SRC = 2'd2;

   generate
      if (DATA_W < 2 * SRC_W) begin : g_bad_src
         $error("DATA_W must hold both source fields");
      end
      if (DATA_W < ST_BITS + VEC_W) begin : g_bad_vec
         $error("DATA_W must hold status flags and message number");
      end
      if (VEC_W < 1) begin : g_bad_vw
         $error("VEC_W must be at least 1");
      end
   endgenerate

   logic [CMD_BITS-1:0] cmd;
   logic [CMD_BITS-1:0] cmd_nxt;
   logic [ST_BITS-1:0]  st;
   logic [ST_BITS-1:0]  st_nxt;
   logic [ST_BITS-1:0]  clr;
   logic [SRC_W-1:0]    src_cor;
   logic [SRC_W-1:0]    src_unc;
   logic [VEC_W-1:0]    vec;
   logic                unused_wbits;

   assign unused_wbits = ^reg_wdata[DATA_W-1:ST_BITS];
   assign clr     = (reg_wr && reg_addr == A_ST) ? reg_wdata[ST_BITS-1:0] : '0;
   assign cmd_nxt = (reg_wr && reg_addr == A_CMD) ? reg_wdata[CMD_BITS-1:0] : cmd;

   always_ff @(posedge clk) begin
      if (!rst_n) cmd <= '0;
      else        cmd <= cmd_nxt;
   end

   rec_status #(.SRC_W(SRC_W)) i_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .msg_valid(msg_valid),
      .msg_sev  (sev_e'(msg_sev)),
      .msg_src  (msg_src),
      .clr      (clr),
      .st       (st),
      .st_nxt   (st_nxt),
      .src_cor  (src_cor),
      .src_unc  (src_unc)
   );

   rec_irq #(.VEC_W(VEC_W), .INTX_REG(INTX_REG)) i_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .msg_mode  (msg_mode),
      .cmd       (cmd),
      .cmd_nxt   (cmd_nxt),
      .st        (st),
      .st_nxt    (st_nxt),
      .vec_load  (vec_load),
      .vec_in    (vec_in),
      .intx_level(intx_level),
      .msi_pulse (msi_pulse),
      .vec       (vec)
   );

   assign msi_vector = vec;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CMD: reg_rdata[CMD_BITS-1:0] = cmd;
         A_ST: begin
            reg_rdata[ST_BITS-1:0]       = st;
            reg_rdata[DATA_W-1 -: VEC_W] = vec;
         end
         A_SRC: begin
            reg_rdata[SRC_W-1:0]       = src_cor;
            reg_rdata[2*SRC_W-1:SRC_W] = src_unc;
         end
         default: ;
      endcase
   end

   // R4: the command register holds unless written at its address
   p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == A_CMD) |=> $stable(cmd));

   // R11: after reset nothing is pending
   p_reset_idle_r11: assert property (@(posedge clk)
      !rst_n |=> (cmd == '0 && st == '0 && !msi_pulse));
endmodule

// File: tb/test_root_err_collector.sv
module test_root_err_collector;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msg_valid = 1'b0;
   logic [1:0]  msg_sev = 2'd0;
   logic [15:0] msg_src = '0;
   logic        msg_mode = 1'b0;
   logic        vec_load = 1'b0;
   logic [4:0]  vec_in = '0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        intx_level;
   logic        msi_pulse;
   logic [4:0]  msi_vector;

   int errors = 0;
   int checks = 0;

   // model state
   logic [2:0]  m_cmd = '0;
   logic [6:0]  m_st = '0;
   logic [15:0] m_sc = '0;
   logic [15:0] m_su = '0;
   logic [4:0]  m_vec = '0;
   logic        m_pulse = 1'b0;

   always #10 clk = ~clk;

   root_err_collector i_root_err_collector (
      .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev),
      .msg_src(msg_src), .msg_mode(msg_mode), .vec_load(vec_load),
      .vec_in(vec_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .intx_level(intx_level),
      .msi_pulse(msi_pulse), .msi_vector(msi_vector)
   );

   function automatic logic en_of(input logic [2:0] c, input logic [6:0] s);
      return |(c & {s[6], s[5], s[0]});
   endfunction

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic check_all();
      reg_addr = 2'd1; #1;
      chk("status (R1,R2,R3,R8,R9,R10)", reg_rdata, {m_vec, 20'd0, m_st});
      reg_addr = 2'd2; #1;
      chk("source (R1,R3,R10)", reg_rdata, {m_su, m_sc});
      reg_addr = 2'd0; #1;
      chk("command (R4)", reg_rdata, {29'd0, m_cmd});
      reg_addr = 2'd3; #1;
      chk("unused address (R4)", reg_rdata, 32'd0);
      chk("intx level (R7)", {31'd0, intx_level}, {31'd0, ~msg_mode & en_of(m_cmd, m_st)});
      chk("msi pulse (R5,R6)", {31'd0, msi_pulse}, {31'd0, m_pulse});
      chk("vector (R8)", {27'd0, msi_vector}, {27'd0, m_vec});
   endtask

   task automatic step(input bit v, input logic [1:0] sv, input logic [15:0] sr,
                       input bit w, input logic [1:0] a, input logic [31:0] d,
                       input bit vl, input logic [4:0] vi);
      logic [6:0] set_b, clr_b, st_n;
      logic [2:0] cmd_n;
      msg_valid = v; msg_sev = sv; msg_src = sr;
      reg_wr = w; reg_addr = a; reg_wdata = d;
      vec_load = vl; vec_in = vi;
      set_b = '0;
      if (v && sv == 2'd0) begin
         if (m_st[0]) set_b[1] = 1'b1;
         set_b[0] = 1'b1;
      end else if (v && (sv == 2'd1 || sv == 2'd2)) begin
         if (m_st[2]) set_b[3] = 1'b1;
         set_b[2] = 1'b1;
         if (sv == 2'd2) begin
            if (!m_st[2]) set_b[4] = 1'b1;
            set_b[6] = 1'b1;
         end else set_b[5] = 1'b1;
      end
      clr_b = (w && a == 2'd1) ? d[6:0] : 7'd0;
      st_n  = (m_st & ~clr_b) | set_b;
      cmd_n = (w && a == 2'd0) ? d[2:0] : m_cmd;
      @(posedge clk);
      m_pulse = msg_mode & ~en_of(m_cmd, m_st) & en_of(cmd_n, st_n);
      if (v && sv == 2'd0 && !m_st[0]) m_sc = sr;
      if (v && (sv == 2'd1 || sv == 2'd2) && !m_st[2]) m_su = sr;
      if (vl) m_vec = vi;
      m_st = st_n;
      m_cmd = cmd_n;
      @(negedge clk);
      msg_valid = 1'b0; reg_wr = 1'b0; vec_load = 1'b0;
      check_all();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog (all) actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int seed_set;
      seed_set = $urandom(32'd24680);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      check_all();

      // level mode directed cases
      step(0, 0, 16'h0, 1, 0, 32'h7, 0, 0);          // R4 enable all
      step(1, 0, 16'hA001, 0, 0, 0, 0, 0);           // R1 first correctable, R7 level
      step(1, 0, 16'hB002, 0, 0, 0, 0, 0);           // R1 multiple, source kept
      step(1, 1, 16'hC003, 0, 0, 0, 0, 0);           // R2 non-fatal, R3 capture upper
      step(1, 2, 16'hD004, 0, 0, 0, 0, 0);           // R2 fatal, no first-fatal; R3 multiple
      step(1, 0, 16'hE005, 1, 1, 32'h7F, 0, 0);      // R9 clear with message same cycle
      step(1, 3, 16'hF006, 0, 0, 0, 0, 0);           // R10 ignored code
      step(0, 0, 16'h0, 1, 1, 32'h7F, 0, 0);         // R9 clear all
      step(1, 2, 16'h1111, 0, 0, 0, 0, 0);           // R2 first-fatal set
      step(0, 0, 16'h0, 1, 0, 32'h0, 0, 0);          // R7 level drops on command write
      step(0, 0, 16'h0, 1, 1, 32'h7F, 0, 0);

      // message mode directed cases
      msg_mode = 1'b1;
      step(0, 0, 16'h0, 0, 0, 0, 1, 5'h15);          // R8 load number
      step(1, 2, 16'h2222, 0, 0, 0, 0, 0);           // R5 not enabled, no pulse
      step(0, 0, 16'h0, 1, 0, 32'h4, 0, 0);          // R6 write makes condition true
      step(0, 0, 16'h0, 1, 0, 32'h6, 0, 0);          // R6 already true, no pulse
      step(0, 0, 16'h0, 1, 1, 32'h7F, 0, 0);
      step(0, 0, 16'h0, 1, 0, 32'h1, 0, 0);
      step(1, 0, 16'h3333, 0, 0, 0, 0, 0);           // R5 enabled correctable pulses
      step(1, 0, 16'h4444, 0, 0, 0, 0, 0);           // R5 already active, no pulse
      step(0, 0, 16'h0, 1, 1, 32'hF800_0000, 0, 0);  // R8 software cannot write number
      step(0, 0, 16'h0, 1, 2, 32'hFFFF_FFFF, 0, 0);  // R4 source is read-only

      // constrained random
      for (int i = 0; i < 600; i++) begin
         bit          v, w, vl;
         logic [1:0]  sv, a;
         logic [31:0] d;
         if ($urandom_range(0, 19) == 0) msg_mode = ~msg_mode;
         v  = ($urandom_range(0, 1) == 1);
         sv = 2'($urandom_range(0, 3));
         w  = ($urandom_range(0, 9) < 3);
         a  = 2'($urandom_range(0, 3));
         d  = $urandom & $urandom;
         vl = ($urandom_range(0, 15) == 0);
         step(v, sv, 16'($urandom), w, a, d, vl, 5'($urandom));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule